// File: doc/BRIEF.md
# Load Driver Fault Supervisor

This block supervises twelve power switch channels, six high-side and six low-side. It takes the control word that software has applied, together with digital fault flags from the analog front end: per-channel overcurrent, supply over- and undervoltage, a thermal warning, a thermal shutdown, per-channel open-load comparators and a hardware run pin. From these it drives one gate enable per channel and builds a 16-bit status word for software to read back.

Every fault that needs time to confirm is measured in ticks of a slow `tick_i` strobe. Overcurrent and overvoltage each have two delays, and one control bit chooses between the short and the long delay. A latched fault stays flagged until software writes a control word with the status-reset bit set and strobes `ctrl_load_i`. The analog comparators and current limiting are outside the block. It sees them only as the flags listed in the port table.

Channel c (0 to 11) is driven by control bit c+1 and reported in status bit c+1. Even channels are low-side and odd channels are high-side. The other control bits are: bit 0 status reset, bit 13 open-load test enable (active low), bit 14 long-delay select, bit 15 software run.

Top module: `load_fault_supervisor`

## Requirements
- R1: When `ovc_i[c]` stays high for SC_SHORT_TICKS ticks (control bit 14 low) or SC_LONG_TICKS ticks (bit 14 high), channel c is latched off, and status bit 13 (short detected) latches high one clock after the last counted tick.
- R2: When `ovc_i[c]` and `twarn_i` are high at the same clock edge, channel c is latched off and status bit 13 is set at that edge, with no delay.
- R3: A delay counter returns to zero in any cycle where its fault input is low, so a fault that drops out before its delay expires never trips.
- R4: When `ov_i` stays high for OV_SHORT_TICKS or OV_LONG_TICKS ticks (chosen by bit 14), or `uv_i` stays high for UV_TICKS ticks, status bit 15 (supply fail) latches high and every gate enable goes low.
- R5: Gate enables come back in the same cycle that the expired supply fault input drops. Status bit 15 stays high until a status reset.
- R6: A status reset (`ctrl_load_i` high with control bit 0 high) clears status bits 13 and 15 and re-enables channels that a short turned off. If a trip happens in the same cycle, the trip wins.
- R7: A high `tshut_i` latches thermal shutdown. Thermal shutdown turns every gate off and forces all 16 status bits high. A status reset releases it only if `tshut_i` is low.
- R8: Status bit 0 equals `twarn_i` in the same cycle and is not latched.
- R9: Status bit c+1 shows `gate_en_o[c]`. When the open-load test is enabled (bit 13 low) and channel c is commanded off, the bit shows `oload_i[c]` instead. Commanding channel c on cancels its test.
- R10: Status bit 14 is high (standby) when `inh_n_i` is low or control bit 15 is low. In standby every gate enable is low.
- R11: A gate enable is high only when its command bit is high, the block is not in standby, the channel has no latched short, no supply fault has expired and thermal shutdown is not active.
- R12: After a synchronous reset all latched flags and counters are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow timebase strobe, one clock wide |
| ctrl_i | input | 16 | Applied control word |
| ctrl_load_i | input | 1 | Strobe marking a newly applied control word (qualifies the status reset) |
| ovc_i | input | 12 | Per-channel overcurrent flags |
| ov_i | input | 1 | Supply overvoltage flag |
| uv_i | input | 1 | Supply undervoltage flag |
| twarn_i | input | 1 | Thermal warning flag |
| tshut_i | input | 1 | Thermal shutdown flag |
| oload_i | input | 12 | Per-channel open-load comparator flags |
| inh_n_i | input | 1 | Hardware run pin, low = standby |
| gate_en_o | output | 12 | Per-channel gate enables |
| status_o | output | 16 | Status word |

## Verification
The embedded properties check the following on every cycle:
- a counter clears whenever its fault is low;
- a warning during an overcurrent latches the channel off at the next edge;
- a status reset with no pending trip releases a channel;
- the supply-fail flag holds and only rises after a supply fault;
- thermal shutdown forces the all-ones word;
- no gate is ever on without its command.

Only the bench scenarios can show the exact delay lengths for both settings of the delay select, the immediate re-enable when the supply recovers, the refused thermal release while the shutdown flag stays high, and the open-load substitution in the status bits. The bench shows these by comparing against its reference model on every clock.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    parameter int NCH = 12;
    parameter int SW  = 16;

    // Applied control word, MSB first
    typedef struct packed {
        logic            run;
        logic            long_dly;
        logic            olt_n;
        logic [NCH-1:0]  chan;
        logic            srr;
    } ctrl_t;

    // Status word, MSB first
    typedef struct packed {
        logic            psf;
        logic            stby;
        logic            scd;
        logic [NCH-1:0]  chan;
        logic            warn;
    } stat_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lfs_delay_timer.sv
module lfs_delay_timer #(
    parameter int CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          fault_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!fault_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < limit_i)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired_o = fault_i && (cnt_q >= limit_i);

    // R3
    restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !fault_i |=> (cnt_q == '0));

endmodule

// File: rtl/lfs_chan_guard.sv
module lfs_chan_guard #(
    parameter int CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          ovc_i,
    input  logic          warn_i,
    input  logic [CW-1:0] limit_i,
    input  logic          srr_i,
    output logic          trip_o,
    output logic          off_o
);

    logic expired;
    logic off_q;

    lfs_delay_timer #(.CW(CW)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .fault_i   (ovc_i),
        .limit_i   (limit_i),
        .expired_o (expired)
    );

    assign trip_o = expired || (ovc_i && warn_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            off_q <= 1'b0;
        end else begin
            off_q <= (off_q && !srr_i) || trip_o;
        end
    end

    assign off_o = off_q;

    // R2
    warn_trip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovc_i && warn_i) |=> off_q);

    // R6
    srr_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (srr_i && !ovc_i) |=> !off_q);

endmodule

// File: rtl/lfs_supply_mon.sv
module lfs_supply_mon #(
    parameter int CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          ov_i,
    input  logic          uv_i,
    input  logic [CW-1:0] ov_limit_i,
    input  logic [CW-1:0] uv_limit_i,
    input  logic          srr_i,
    output logic          supply_off_o,
    output logic          psf_o
);

    logic ov_exp;
    logic uv_exp;
    logic psf_q;

    lfs_delay_timer #(.CW(CW)) u_ov_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .fault_i   (ov_i),
        .limit_i   (ov_limit_i),
        .expired_o (ov_exp)
    );

    lfs_delay_timer #(.CW(CW)) u_uv_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .fault_i   (uv_i),
        .limit_i   (uv_limit_i),
        .expired_o (uv_exp)
    );

    assign supply_off_o = ov_exp || uv_exp;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            psf_q <= 1'b0;
        end else begin
            psf_q <= (psf_q && !srr_i) || supply_off_o;
        end
    end

    assign psf_o = psf_q;

    // R4
    psf_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(psf_q) |-> $past(ov_i || uv_i));

    // R5
    psf_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (psf_q && !srr_i) |=> psf_q);

endmodule

// File: rtl/lfs_status_pack.sv
module lfs_status_pack
    import lfs_pkg::*;
(
    input  logic           therm_i,
    input  logic           warn_i,
    input  logic           olt_en_i,
    input  logic [NCH-1:0] cmd_i,
    input  logic [NCH-1:0] gate_i,
    input  logic [NCH-1:0] oload_i,
    input  logic           scd_i,
    input  logic           stby_i,
    input  logic           psf_i,
    output logic [SW-1:0]  status_o
);

    logic [NCH-1:0] chan_bits;
    stat_t          st;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign chan_bits[g] = (olt_en_i && !cmd_i[g]) ? oload_i[g] : gate_i[g];
    end

    always_comb begin
        st.psf  = psf_i;
        st.stby = stby_i;
        st.scd  = scd_i;
        st.chan = chan_bits;
        st.warn = warn_i;
        status_o = therm_i ? {SW{1'b1}} : SW'(st);
    end

endmodule

// File: rtl/load_fault_supervisor.sv
module load_fault_supervisor
    import lfs_pkg::*;
#(
    parameter int SC_LONG_TICKS  = 800,
    parameter int SC_SHORT_TICKS = 100,
    parameter int OV_LONG_TICKS  = 120,
    parameter int OV_SHORT_TICKS = 28,
    parameter int UV_TICKS       = 28
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           tick_i,
    input  logic [SW-1:0]  ctrl_i,
    input  logic           ctrl_load_i,
    input  logic [NCH-1:0] ovc_i,
    input  logic           ov_i,
    input  logic           uv_i,
    input  logic           twarn_i,
    input  logic           tshut_i,
    input  logic [NCH-1:0] oload_i,
    input  logic           inh_n_i,
    output logic [NCH-1:0] gate_en_o,
    output logic [SW-1:0]  status_o
);

    localparam int MAXT = max2(max2(SC_LONG_TICKS, SC_SHORT_TICKS),
                               max2(max2(OV_LONG_TICKS, OV_SHORT_TICKS), UV_TICKS));
    localparam int CW   = cnt_width(MAXT);

    ctrl_t          ctl;
    logic           srr;
    logic           standby;
    logic [CW-1:0]  sc_lim;
    logic [CW-1:0]  ov_lim;
    logic [NCH-1:0] trip;
    logic [NCH-1:0] sc_off;
    logic           scd_q;
    logic           therm_q;
    logic           supply_off;
    logic           psf;

    assign ctl     = ctrl_t'(ctrl_i);
    assign srr     = ctrl_load_i && ctl.srr;
    assign standby = !inh_n_i || !ctl.run;
    assign sc_lim  = ctl.long_dly ? CW'(SC_LONG_TICKS) : CW'(SC_SHORT_TICKS);
    assign ov_lim  = ctl.long_dly ? CW'(OV_LONG_TICKS) : CW'(OV_SHORT_TICKS);

    for (genvar g = 0; g < NCH; g++) begin : g_guard
        lfs_chan_guard #(.CW(CW)) u_guard (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .tick_i  (tick_i),
            .ovc_i   (ovc_i[g]),
            .warn_i  (twarn_i),
            .limit_i (sc_lim),
            .srr_i   (srr),
            .trip_o  (trip[g]),
            .off_o   (sc_off[g])
        );
    end

    lfs_supply_mon #(.CW(CW)) u_supply (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (tick_i),
        .ov_i         (ov_i),
        .uv_i         (uv_i),
        .ov_limit_i   (ov_lim),
        .uv_limit_i   (CW'(UV_TICKS)),
        .srr_i        (srr),
        .supply_off_o (supply_off),
        .psf_o        (psf)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            scd_q   <= 1'b0;
            therm_q <= 1'b0;
        end else begin
            scd_q   <= (scd_q && !srr) || (|trip);
            therm_q <= therm_q ? !(srr && !tshut_i) : tshut_i;
        end
    end

    assign gate_en_o = ctl.chan & ~sc_off
                     & {NCH{!(standby || supply_off || therm_q)}};

    lfs_status_pack u_status (
        .therm_i  (therm_q),
        .warn_i   (twarn_i),
        .olt_en_i (!ctl.olt_n),
        .cmd_i    (ctl.chan),
        .gate_i   (gate_en_o),
        .oload_i  (oload_i),
        .scd_i    (scd_q),
        .stby_i   (standby),
        .psf_i    (psf),
        .status_o (status_o)
    );

    // R7
    therm_ones_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        therm_q |-> (status_o == {SW{1'b1}}));

    // R7
    therm_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (therm_q && tshut_i) |=> therm_q);

    // R11
    gate_cmd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_en_o & ~ctrl_i[NCH:1]) == '0);

endmodule

// File: tb/tb_load_fault_supervisor.sv
`timescale 1ns/1ps
module tb_load_fault_supervisor;

    localparam int NCH = 12;
    localparam int SCL = 800, SCS = 100, OVL = 120, OVS = 28, UVT = 28;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic tick_i = 1'b0;
    logic [15:0] ctrl_i = '0;
    logic ctrl_load_i = 1'b0;
    logic [NCH-1:0] ovc_i = '0;
    logic ov_i = 1'b0, uv_i = 1'b0, twarn_i = 1'b0, tshut_i = 1'b0;
    logic [NCH-1:0] oload_i = '0;
    logic inh_n_i = 1'b0;
    logic [NCH-1:0] gate_en_o;
    logic [15:0] status_o;

    int checks = 0, fails = 0;
    string cur_req = "R12";
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    load_fault_supervisor #(
        .SC_LONG_TICKS(SCL), .SC_SHORT_TICKS(SCS),
        .OV_LONG_TICKS(OVL), .OV_SHORT_TICKS(OVS), .UV_TICKS(UVT)
    ) dut (
        .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .ctrl_i(ctrl_i),
        .ctrl_load_i(ctrl_load_i), .ovc_i(ovc_i), .ov_i(ov_i), .uv_i(uv_i),
        .twarn_i(twarn_i), .tshut_i(tshut_i), .oload_i(oload_i),
        .inh_n_i(inh_n_i), .gate_en_o(gate_en_o), .status_o(status_o)
    );

    // ---------------- reference model ----------------
    int  m_sc[NCH];
    bit  m_off[NCH];
    int  m_ov, m_uv;
    bit  m_scd, m_psf, m_th;

    function automatic int sc_limit();
        return ctrl_i[14] ? SCL : SCS;
    endfunction
    function automatic int ov_limit();
        return ctrl_i[14] ? OVL : OVS;
    endfunction

    always @(posedge clk) begin
        if (rst_i) begin
            for (int c = 0; c < NCH; c++) begin m_sc[c] = 0; m_off[c] = 0; end
            m_ov = 0; m_uv = 0; m_scd = 0; m_psf = 0; m_th = 0;
        end else begin
            bit srr, any, tr, sup;
            srr = ctrl_load_i && ctrl_i[0];
            any = 0;
            for (int c = 0; c < NCH; c++) begin
                tr = ovc_i[c] && ((m_sc[c] >= sc_limit()) || twarn_i);
                if (tr) any = 1;
                m_off[c] = (m_off[c] && !srr) || tr;
                if (!ovc_i[c]) m_sc[c] = 0;
                else if (tick_i && m_sc[c] < sc_limit()) m_sc[c]++;
            end
            sup = (ov_i && m_ov >= ov_limit()) || (uv_i && m_uv >= UVT);
            m_psf = (m_psf && !srr) || sup;
            if (!ov_i) m_ov = 0; else if (tick_i && m_ov < ov_limit()) m_ov++;
            if (!uv_i) m_uv = 0; else if (tick_i && m_uv < UVT) m_uv++;
            m_scd = (m_scd && !srr) || any;
            m_th  = m_th ? !(srr && !tshut_i) : tshut_i;
        end
    end

    function automatic logic [NCH-1:0] exp_gate();
        logic [NCH-1:0] g;
        bit stby, sup;
        stby = !inh_n_i || !ctrl_i[15];
        sup  = (ov_i && m_ov >= ov_limit()) || (uv_i && m_uv >= UVT);
        for (int c = 0; c < NCH; c++)
            g[c] = ctrl_i[c+1] && !stby && !m_off[c] && !sup && !m_th;
        return g;
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        logic [NCH-1:0] g;
        if (m_th) return 16'hFFFF;
        g = exp_gate();
        s[0] = twarn_i;
        for (int c = 0; c < NCH; c++)
            s[c+1] = (!ctrl_i[13] && !ctrl_i[c+1]) ? oload_i[c] : g[c];
        s[13] = m_scd;
        s[14] = !inh_n_i || !ctrl_i[15];
        s[15] = m_psf;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check({cur_req, " gates"},  32'(gate_en_o), 32'(exp_gate()));
            check({cur_req, " status"}, 32'(status_o),  32'(exp_status()));
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        forever begin
            @(posedge clk); #1;
            tick_i = ~tick_i;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] cw(bit run, bit lng, bit oltn, logic [NCH-1:0] ch);
        return {run, lng, oltn, ch, 1'b0};
    endfunction

    task automatic status_reset();
        ctrl_i[0] = 1'b1; ctrl_load_i = 1'b1;
        cyc(1);
        ctrl_i[0] = 1'b0; ctrl_load_i = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        cyc(3);
        rst_i = 1'b0;
        cmp_en = 1'b1;
        cur_req = "R12";
        @(negedge clk);
        check("R12 reset status", 32'(status_o), 32'h4000);
        check("R12 reset gates", 32'(gate_en_o), 32'h0);
        cyc(2);

        cur_req = "R10";
        ctrl_i = cw(1, 0, 1, 12'hA5C); inh_n_i = 1'b1;
        cyc(4);
        @(negedge clk);
        check("R11 gates follow command", 32'(gate_en_o), 32'hA5C);
        inh_n_i = 1'b0; cyc(1);
        @(negedge clk);
        check("R10 pin standby gates off", 32'(gate_en_o), 32'h0);
        check("R10 standby bit", 32'(status_o[14]), 32'h1);
        inh_n_i = 1'b1; ctrl_i[15] = 1'b0; cyc(3);
        ctrl_i[15] = 1'b1; cyc(2);

        cur_req = "R9";
        oload_i = 12'h3C3; ctrl_i = cw(1, 0, 0, 12'h0F0); cyc(3);
        @(negedge clk);
        check("R9 open-load substitution", 32'(status_o[12:1]), 32'h3F3);
        ctrl_i = cw(1, 0, 1, 12'h0F0); cyc(3);
        oload_i = '0;

        cur_req = "R8";
        twarn_i = 1'b1; cyc(1);
        @(negedge clk);
        check("R8 warning bit", 32'(status_o[0]), 32'h1);
        twarn_i = 1'b0; cyc(1);
        @(negedge clk);
        check("R8 warning not latched", 32'(status_o[0]), 32'h0);

        cur_req = "R1";
        ctrl_i = cw(1, 0, 1, 12'hFFF); cyc(2);
        ovc_i[3] = 1'b1; cyc(2 * SCS + 6);
        @(negedge clk);
        check("R1 short delay trip", 32'(gate_en_o[3]), 32'h0);
        check("R1 short flag", 32'(status_o[13]), 32'h1);
        ovc_i[3] = 1'b0; cyc(2);
        cur_req = "R6";
        status_reset(); cyc(2);
        @(negedge clk);
        check("R6 channel re-enabled", 32'(gate_en_o[3]), 32'h1);
        cur_req = "R1";
        ctrl_i[14] = 1'b1; ovc_i[7] = 1'b1; cyc(2 * SCS + 10);
        @(negedge clk);
        check("R1 long delay not yet", 32'(gate_en_o[7]), 32'h1);
        cyc(2 * SCL);
        ovc_i[7] = 1'b0; status_reset(); ctrl_i[14] = 1'b0; cyc(2);

        cur_req = "R3";
        ovc_i[5] = 1'b1; cyc(2 * SCS - 20);
        ovc_i[5] = 1'b0; cyc(2);
        ovc_i[5] = 1'b1; cyc(2 * SCS - 20);
        @(negedge clk);
        check("R3 restart no trip", 32'(gate_en_o[5]), 32'h1);
        ovc_i[5] = 1'b0; cyc(2);

        cur_req = "R2";
        ovc_i[10] = 1'b1; cyc(3);
        twarn_i = 1'b1; cyc(1);
        @(negedge clk);
        check("R2 immediate trip", 32'(gate_en_o[10]), 32'h0);
        twarn_i = 1'b0; ovc_i[10] = 1'b0; cyc(1);
        cur_req = "R6";
        ovc_i[1] = 1'b1; twarn_i = 1'b1; status_reset();
        twarn_i = 1'b0; ovc_i[1] = 1'b0; cyc(2);
        status_reset(); cyc(2);

        cur_req = "R4";
        ov_i = 1'b1; cyc(2 * OVS + 6);
        @(negedge clk);
        check("R4 overvoltage off", 32'(gate_en_o), 32'h0);
        check("R4 supply flag", 32'(status_o[15]), 32'h1);
        cur_req = "R5";
        ov_i = 1'b0;
        @(negedge clk);
        check("R5 immediate recovery", 32'(gate_en_o), 32'hFFF);
        check("R5 flag kept", 32'(status_o[15]), 32'h1);
        cyc(3);
        status_reset(); cyc(2);
        cur_req = "R4";
        ctrl_i[14] = 1'b1; ov_i = 1'b1; cyc(2 * OVL + 6);
        ov_i = 1'b0; ctrl_i[14] = 1'b0;
        uv_i = 1'b1; cyc(2 * UVT + 6);
        uv_i = 1'b0; cyc(2); status_reset(); cyc(2);

        cur_req = "R7";
        tshut_i = 1'b1; cyc(2);
        @(negedge clk);
        check("R7 all ones", 32'(status_o), 32'hFFFF);
        status_reset(); cyc(2);
        @(negedge clk);
        check("R7 release refused", 32'(gate_en_o), 32'h0);
        tshut_i = 1'b0; cyc(3);
        status_reset(); cyc(2);
        @(negedge clk);
        check("R7 released", 32'(gate_en_o), 32'hFFF);

        cur_req = "R12";
        ovc_i[0] = 1'b1; cyc(20);
        rst_i = 1'b1; cmp_en = 1'b0; cyc(2);
        rst_i = 1'b0; ovc_i[0] = 1'b0; cmp_en = 1'b1; cyc(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule